// File: doc/BRIEF.md
# Exception Status and Cause Unit

This block is the privileged control-register side of a small 32-bit processor's trap handling. It keeps four registers: the faulting address, a status word, a cause word and the return address of the trapped instruction. When the pipeline reports a synchronous exception, or accepts an interrupt request, the unit captures the trap state in one clock edge. It records the trapped PC and the exception code. It pushes the interrupt-enable and user/kernel pair down a three-level stack held in the low status bits. In the same cycle it tells fetch to jump to the fixed handler vector.

A return-from-exception strobe pops that stack. The enable bit and the mode bit therefore come back together, and interrupts cannot be re-enabled while the mode is still wrong. Hardware interrupt lines set sticky pending bits in the cause word. The unit raises a request when the current enable is on and a pending level is also unmasked in the status word. Software reaches the registers through a move-to write port and a combinational move-from read port. Each register has a fixed selector number.

Top module: `trap_ctl`

## Requirements
- R1: After reset, all four registers read zero, so the unit starts in kernel mode with interrupts disabled, and `irq_req` and `redirect_en` are low.
- R2: The selector numbers are 8 for the fault address, 12 for status, 13 for cause and 14 for the return PC. Any other selector reads zero.
- R3: When `exc_valid` or `irq_ack` is high, `redirect_en` is high in that same cycle and `redirect_pc` is 0x80000080. After that edge, the return PC holds `exc_pc` and cause bits 5:2 hold the trap code. `redirect_en` is low in any cycle without a trap.
- R4: Status bits 1:0, 3:2 and 5:4 hold the current, previous and old pairs. In each pair, the lower bit is interrupt enable and the upper bit is mode, with 0 meaning kernel. On a trap, old takes previous, previous takes current, and current becomes 00 (kernel, disabled).
- R5: A `rfe` strobe moves previous into current and old into previous in a single edge. The old pair keeps its value.
- R6: The fault-address register loads `exc_vaddr` only for a synchronous exception whose code lies in 2 to 5. Other codes and interrupts leave it unchanged.
- R7: Cause bits 15:11 are pending flags, one per interrupt line (line k maps to bit 11+k). A line seen high sets its flag even while interrupts are disabled or masked. The flag stays set until software writes a 0 to that bit of the cause register.
- R8: Status bits 15:11 are a mask aligned with the pending flags. `irq_req` is high only when the current enable is 1 and at least one pending flag has its mask bit set.
- R9: An interrupt taken alone records code 0. When `exc_valid` and `irq_ack` are both high, the exception's code and PC are recorded and the pending flags are untouched.
- R10: A trap takes priority over `rfe` and over a move-to write in the same cycle; those are dropped. A `rfe` takes priority over a move-to write.
- R11: Software may write status bits 15:11 and 5:0 and cause bits 15:11. It may write the return PC only while the current mode is kernel. The fault address is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Synchronous exception taken this cycle |
| exc_code | input | 4 | Exception code |
| exc_pc | input | 32 | PC of the trapped instruction |
| exc_vaddr | input | 32 | Faulting virtual address |
| irq_ack | input | 1 | Pipeline takes the pending interrupt this cycle |
| rfe | input | 1 | Return-from-exception strobe |
| irq_lines | input | 5 | Hardware interrupt lines |
| mt_en | input | 1 | Move-to register write strobe |
| mt_sel | input | 5 | Move-to register selector |
| mt_data | input | 32 | Move-to write data |
| mf_sel | input | 5 | Move-from register selector |
| mf_data | output | 32 | Move-from read data (combinational) |
| redirect_en | output | 1 | Fetch must jump to the handler vector |
| redirect_pc | output | 32 | Handler vector address |
| irq_req | output | 1 | Interrupt request to the pipeline |

## Verification
`redirect_en` and `redirect_pc` are due in the same cycle as the trap strobe. Every register effect of a trap, `rfe`, interrupt line or move-to write is visible on `mf_data` one edge later, and so is `irq_req`, because it depends only on registered state. The driver changes inputs 5 ns after a rising edge and queues the values due in that cycle. The monitor pops and compares them at the falling edge, so each check samples one half period before the edge that could change the result. With the default of no synchroniser stages, a line held high for one cycle shows as pending in the next.

// File: rtl/trap_pkg.sv
package trap_pkg;

   // selector numbers shared by the move-to and move-from ports
   typedef enum logic [4:0] {
      SEL_FAULT  = 5'd8,
      SEL_STATUS = 5'd12,
      SEL_CAUSE  = 5'd13,
      SEL_RETPC  = 5'd14
   } cp_sel_e;

   // one enable/mode pair; mode 0 means kernel
   typedef struct packed {
      logic user;
      logic ie;
   } mode_pair_t;

   localparam int unsigned CODE_LSB = 2;
   localparam int unsigned PEND_LSB = 11;

endpackage

// File: rtl/trap_mode_stack.sv
module trap_mode_stack
   import trap_pkg::*;
#(
   parameter int unsigned DEPTH = 3,
   localparam int unsigned SW = 2 * DEPTH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_data,
   output logic [SW-1:0] stack_q
);

   mode_pair_t [DEPTH-1:0] lvl_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      mode_pair_t shift_in;
      mode_pair_t shift_out;
      mode_pair_t nxt;

      if (i == 0) begin : g_bottom
         assign shift_in = '0;
      end else begin : g_upper
         assign shift_in = lvl_q[i-1];
      end

      if (i == DEPTH - 1) begin : g_top
         assign shift_out = lvl_q[i];
      end else begin : g_below
         assign shift_out = lvl_q[i+1];
      end

      always_comb begin
         nxt = lvl_q[i];
         if (push) begin
            nxt = shift_in;
         end else if (pop) begin
            nxt = shift_out;
         end else if (wr_en) begin
            nxt = wr_data[2*i +: 2];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl_q[i] <= '0;
         end else begin
            lvl_q[i] <= nxt;
         end
      end
   end

   assign stack_q = lvl_q;

endmodule

// File: rtl/trap_cause.sv
module trap_cause #(
   parameter int unsigned NLVL        = 5,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [CODE_W-1:0] code_in,
   input  logic [NLVL-1:0]   lines,
   input  logic              sw_wr,
   input  logic [NLVL-1:0]   sw_pend,
   output logic [NLVL-1:0]   pend_q,
   output logic [CODE_W-1:0] code_q
);

   logic [NLVL-1:0] lines_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign lines_s = lines;
   end else begin : g_sync
      logic [NLVL-1:0] sr [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) sr[k] <= '0;
         end else begin
            sr[0] <= lines;
            for (int k = 1; k < SYNC_STAGES; k++) sr[k] <= sr[k-1];
         end
      end
      assign lines_s = sr[SYNC_STAGES-1];
   end

   logic [NLVL-1:0] kept;
   assign kept = sw_wr ? (pend_q & sw_pend) : pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         code_q <= '0;
      end else begin
         pend_q <= kept | lines_s;
         if (take) code_q <= code_in;
      end
   end

endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
   import trap_pkg::*;
#(
   parameter int unsigned XLEN            = 32,
   parameter int unsigned NLVL            = 5,
   parameter int unsigned CODE_W          = 4,
   parameter int unsigned STACK_DEPTH     = 3,
   parameter logic [31:0] VECTOR          = 32'h8000_0080,
   parameter int unsigned ADDR_CODE_LO    = 2,
   parameter int unsigned ADDR_CODE_HI    = 5,
   parameter int unsigned IRQ_CODE        = 0,
   parameter int unsigned IRQ_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic [XLEN-1:0]   exc_vaddr,
   input  logic              irq_ack,
   input  logic              rfe,
   input  logic [NLVL-1:0]   irq_lines,
   input  logic              mt_en,
   input  logic [4:0]        mt_sel,
   input  logic [XLEN-1:0]   mt_data,
   input  logic [4:0]        mf_sel,
   output logic [XLEN-1:0]   mf_data,
   output logic              redirect_en,
   output logic [XLEN-1:0]   redirect_pc,
   output logic              irq_req
);

   localparam int unsigned SW = 2 * STACK_DEPTH;

   if (PEND_LSB + NLVL > XLEN) begin : g_chk_pend
      $error("pending field does not fit the register width");
   end
   if (SW > PEND_LSB) begin : g_chk_stack
      $error("mode stack overlaps the mask field");
   end
   if (CODE_LSB + CODE_W > PEND_LSB) begin : g_chk_code
      $error("code field overlaps the pending field");
   end
   if (XLEN != 32) begin : g_chk_xlen
      $error("vector parameter assumes a 32-bit word");
   end

   logic                take;
   logic [CODE_W-1:0]   take_code;
   logic                pop;
   logic                sw_ok;
   logic                kernel;
   logic                addr_fault;
   logic [SW-1:0]       stack_q;
   logic [NLVL-1:0]     mask_q;
   logic [NLVL-1:0]     pend_q;
   logic [CODE_W-1:0]   code_q;
   logic [XLEN-1:0]     epc_q;
   logic [XLEN-1:0]     fault_q;
   logic [XLEN-1:0]     status_rd;
   logic [XLEN-1:0]     cause_rd;

   assign take       = exc_valid | irq_ack;
   assign take_code  = exc_valid ? exc_code : CODE_W'(IRQ_CODE);
   assign pop        = rfe & ~take;
   assign sw_ok      = mt_en & ~take & ~rfe;
   assign kernel     = ~stack_q[1];
   assign addr_fault = exc_valid
                       && (32'(exc_code) >= ADDR_CODE_LO)
                       && (32'(exc_code) <= ADDR_CODE_HI);

   trap_mode_stack #(
      .DEPTH (STACK_DEPTH)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (take),
      .pop     (pop),
      .wr_en   (sw_ok && (mt_sel == SEL_STATUS)),
      .wr_data (mt_data[SW-1:0]),
      .stack_q (stack_q)
   );

   trap_cause #(
      .NLVL        (NLVL),
      .CODE_W      (CODE_W),
      .SYNC_STAGES (IRQ_SYNC_STAGES)
   ) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .code_in (take_code),
      .lines   (irq_lines),
      .sw_wr   (sw_ok && (mt_sel == SEL_CAUSE)),
      .sw_pend (mt_data[PEND_LSB +: NLVL]),
      .pend_q  (pend_q),
      .code_q  (code_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q   <= '0;
         fault_q <= '0;
         mask_q  <= '0;
      end else begin
         if (take) begin
            epc_q <= exc_pc;
         end else if (sw_ok && (mt_sel == SEL_RETPC) && kernel) begin
            epc_q <= mt_data;
         end
         if (addr_fault) fault_q <= exc_vaddr;
         if (sw_ok && (mt_sel == SEL_STATUS)) mask_q <= mt_data[PEND_LSB +: NLVL];
      end
   end

   always_comb begin
      status_rd = '0;
      status_rd[SW-1:0] = stack_q;
      status_rd[PEND_LSB +: NLVL] = mask_q;
      cause_rd = '0;
      cause_rd[CODE_LSB +: CODE_W] = code_q;
      cause_rd[PEND_LSB +: NLVL] = pend_q;
   end

   always_comb begin
      case (mf_sel)
         SEL_FAULT:  mf_data = fault_q;
         SEL_STATUS: mf_data = status_rd;
         SEL_CAUSE:  mf_data = cause_rd;
         SEL_RETPC:  mf_data = epc_q;
         default:    mf_data = '0;
      endcase
   end

   assign redirect_en = take;
   assign redirect_pc = VECTOR;
   assign irq_req     = stack_q[0] & (|(pend_q & mask_q));

endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NLVL = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_valid,
   input logic            irq_ack,
   input logic            rfe,
   input logic            mt_en,
   input logic [4:0]      mt_sel,
   input logic [XLEN-1:0] exc_pc,
   input logic [XLEN-1:0] status_rd,
   input logic [XLEN-1:0] cause_rd,
   input logic [XLEN-1:0] epc_q,
   input logic            irq_req
);

   logic trap;
   logic cause_wr;
   logic epc_user_wr;
   assign trap        = exc_valid | irq_ack;
   assign cause_wr    = mt_en && (mt_sel == 5'd13) && !trap && !rfe;
   assign epc_user_wr = mt_en && (mt_sel == 5'd14) && status_rd[1] && !trap && !rfe;

   // R4: a trap enters kernel with interrupts disabled
   a_r4_enter_kernel: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> status_rd[1:0] == 2'b00);

   // R4: the lower pairs move up one level on a trap
   a_r4_push: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> status_rd[5:2] == $past(status_rd[3:0]));

   // R5: return restores both bits of each pair together
   a_r5_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe && !trap) |=> (status_rd[3:0] == $past(status_rd[5:2]))
                         && (status_rd[5:4] == $past(status_rd[5:4])));

   // R3: return PC captures the trapped instruction
   a_r3_epc: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> epc_q == $past(exc_pc));

   // R7: pending flags only drop through a software cause write
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wr |=> (cause_rd[11 +: NLVL] & $past(cause_rd[11 +: NLVL]))
                    == $past(cause_rd[11 +: NLVL]));

   // R8: no request while the current enable is off
   a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !status_rd[0] |-> !irq_req);

   // R11: user mode cannot change the return PC
   a_r11_user_epc: assert property (@(posedge clk) disable iff (!rst_n)
      epc_user_wr |=> $stable(epc_q));

endmodule

bind trap_ctl trap_ctl_chk #(
   .XLEN (XLEN),
   .NLVL (NLVL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exc_valid (exc_valid),
   .irq_ack   (irq_ack),
   .rfe       (rfe),
   .mt_en     (mt_en),
   .mt_sel    (mt_sel),
   .exc_pc    (exc_pc),
   .status_rd (status_rd),
   .cause_rd  (cause_rd),
   .epc_q     (epc_q),
   .irq_req   (irq_req)
);

// File: tb/trap_ctl_bench.sv
module trap_ctl_bench;

   localparam logic [4:0] S_FAULT  = 5'd8;
   localparam logic [4:0] S_STATUS = 5'd12;
   localparam logic [4:0] S_CAUSE  = 5'd13;
   localparam logic [4:0] S_RETPC  = 5'd14;

   localparam int K_RD  = 0;
   localparam int K_RED = 1;
   localparam int K_VEC = 2;
   localparam int K_IRQ = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [3:0]  exc_code = '0;
   logic [31:0] exc_pc = '0;
   logic [31:0] exc_vaddr = '0;
   logic        irq_ack = 1'b0;
   logic        rfe = 1'b0;
   logic [4:0]  irq_lines = '0;
   logic        mt_en = 1'b0;
   logic [4:0]  mt_sel = '0;
   logic [31:0] mt_data = '0;
   logic [4:0]  mf_sel = '0;
   logic [31:0] mf_data;
   logic        redirect_en;
   logic [31:0] redirect_pc;
   logic        irq_req;

   always #10 clk = ~clk;

   trap_ctl u_trap_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .exc_valid   (exc_valid),
      .exc_code    (exc_code),
      .exc_pc      (exc_pc),
      .exc_vaddr   (exc_vaddr),
      .irq_ack     (irq_ack),
      .rfe         (rfe),
      .irq_lines   (irq_lines),
      .mt_en       (mt_en),
      .mt_sel      (mt_sel),
      .mt_data     (mt_data),
      .mf_sel      (mf_sel),
      .mf_data     (mf_data),
      .redirect_en (redirect_en),
      .redirect_pc (redirect_pc),
      .irq_req     (irq_req)
   );

   typedef struct {
      string       req;
      int          kind;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 0;

   task automatic expect_val(input string req, input int kind, input logic [31:0] exp);
      item_t it;
      it.req  = req;
      it.kind = kind;
      it.exp  = exp;
      q.push_back(it);
   endtask

   // monitor: compares queued items half a period before the next edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = q.pop_front();
         case (it.kind)
            K_RD:    got = mf_data;
            K_RED:   got = {31'd0, redirect_en};
            K_VEC:   got = redirect_pc;
            default: got = {31'd0, irq_req};
         endcase
         n_run++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #5;
   endtask

   task automatic rd(input logic [4:0] sel, input logic [31:0] exp, input string req);
      mf_sel = sel;
      expect_val(req, K_RD, exp);
      cyc();
   endtask

   task automatic mtc(input logic [4:0] sel, input logic [31:0] data);
      mt_en = 1'b1;
      mt_sel = sel;
      mt_data = data;
      cyc();
      mt_en = 1'b0;
   endtask

   task automatic trap(input logic [3:0] code, input logic [31:0] pc, input logic [31:0] va,
                       input logic with_irq, input logic with_rfe);
      exc_valid = 1'b1;
      exc_code  = code;
      exc_pc    = pc;
      exc_vaddr = va;
      irq_ack   = with_irq;
      rfe       = with_rfe;
      expect_val("R3 redirect", K_RED, 32'd1);
      expect_val("R3 vector", K_VEC, 32'h8000_0080);
      cyc();
      exc_valid = 1'b0;
      irq_ack   = 1'b0;
      rfe       = 1'b0;
   endtask

   task automatic pulse_line(input logic [4:0] l);
      irq_lines = l;
      cyc();
      irq_lines = '0;
   endtask

   task automatic do_rfe();
      rfe = 1'b1;
      cyc();
      rfe = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) cyc();
      rst_n = 1'b1;

      // R1 reset state, R2 selector map
      rd(S_STATUS, 32'h0, "R1 status");
      rd(S_CAUSE, 32'h0, "R1 cause");
      rd(S_RETPC, 32'h0, "R1 retpc");
      rd(S_FAULT, 32'h0, "R1 fault");
      expect_val("R1 irq_req", K_IRQ, 32'd0);
      expect_val("R1 redirect", K_RED, 32'd0);
      rd(5'd3, 32'h0, "R2 unmapped");

      // R11 software writes
      mtc(S_RETPC, 32'hAAAA_0000);
      rd(S_RETPC, 32'hAAAA_0000, "R11 kernel retpc write");
      mtc(S_STATUS, 32'hFFFF_F803);
      rd(S_STATUS, 32'h0000_F803, "R11 status fields");
      mtc(S_RETPC, 32'h0000_1234);
      rd(S_RETPC, 32'hAAAA_0000, "R11 user retpc ignored");
      mtc(S_FAULT, 32'h1111_1111);
      rd(S_FAULT, 32'h0, "R11 fault read-only");

      // R3/R4/R6 first trap, address code 4
      trap(4'd4, 32'h0040_0010, 32'hDEAD_0001, 1'b0, 1'b0);
      rd(S_RETPC, 32'h0040_0010, "R3 retpc");
      rd(S_CAUSE, 32'h0000_0010, "R3 cause code");
      rd(S_FAULT, 32'hDEAD_0001, "R6 fault load");
      rd(S_STATUS, 32'h0000_F80C, "R4 push one");
      expect_val("R3 no redirect idle", K_RED, 32'd0);

      // R4 nested trap, non-address code 8
      mtc(S_STATUS, 32'h0000_F80D);
      trap(4'd8, 32'h8000_0100, 32'h0000_5555, 1'b0, 1'b0);
      rd(S_STATUS, 32'h0000_F834, "R4 push two");
      rd(S_CAUSE, 32'h0000_0020, "R3 cause code 8");
      rd(S_FAULT, 32'hDEAD_0001, "R6 fault kept code 8");

      // R5 returns
      do_rfe();
      rd(S_STATUS, 32'h0000_F83D, "R5 pop one");
      do_rfe();
      rd(S_STATUS, 32'h0000_F83F, "R5 pop two");

      // R7/R8 pending and request
      mtc(S_STATUS, 32'h0000_2001);
      pulse_line(5'b00001);
      expect_val("R8 masked level", K_IRQ, 32'd0);
      rd(S_CAUSE, 32'h0000_0820, "R7 pending level0");
      pulse_line(5'b00100);
      expect_val("R8 unmasked level", K_IRQ, 32'd1);
      rd(S_CAUSE, 32'h0000_2820, "R7 pending level2");
      mtc(S_STATUS, 32'h0000_2000);
      expect_val("R8 disabled", K_IRQ, 32'd0);
      pulse_line(5'b10000);
      rd(S_CAUSE, 32'h0000_A820, "R7 pending while disabled");
      mtc(S_STATUS, 32'h0000_2001);
      expect_val("R8 re-enabled", K_IRQ, 32'd1);
      cyc();

      // R9 simultaneous exception and interrupt
      trap(4'd12, 32'h0000_0100, 32'h0000_7777, 1'b1, 1'b0);
      rd(S_CAUSE, 32'h0000_A830, "R9 sync code wins");
      rd(S_RETPC, 32'h0000_0100, "R9 sync pc");
      rd(S_STATUS, 32'h0000_2004, "R4 push on combined");

      // R9 interrupt alone records code 0
      do_rfe();
      exc_pc  = 32'h0000_0200;
      irq_ack = 1'b1;
      expect_val("R3 redirect irq", K_RED, 32'd1);
      cyc();
      irq_ack = 1'b0;
      rd(S_CAUSE, 32'h0000_A800, "R9 irq code 0");
      rd(S_RETPC, 32'h0000_0200, "R9 irq pc");
      rd(S_FAULT, 32'hDEAD_0001, "R6 fault kept irq");

      // R7 clear by software
      mtc(S_CAUSE, 32'h0000_8000);
      rd(S_CAUSE, 32'h0000_8000, "R7 software clear");

      // R10 trap over rfe, code 6 is not an address code
      trap(4'd6, 32'h0000_0300, 32'h0000_9999, 1'b0, 1'b1);
      rd(S_STATUS, 32'h0000_2010, "R10 trap beats rfe");
      rd(S_CAUSE, 32'h0000_8018, "R3 cause code 6");
      rd(S_FAULT, 32'hDEAD_0001, "R6 fault kept code 6");

      // R10 trap over move-to, code 2 is an address code
      mt_en   = 1'b1;
      mt_sel  = S_STATUS;
      mt_data = 32'h0000_FFFF;
      trap(4'd2, 32'h0000_0400, 32'h0000_BEEF, 1'b0, 1'b0);
      mt_en   = 1'b0;
      rd(S_STATUS, 32'h0000_2000, "R10 trap beats move-to");
      rd(S_FAULT, 32'h0000_BEEF, "R6 fault load code 2");

      // R10 rfe over move-to
      rfe     = 1'b1;
      mt_en   = 1'b1;
      mt_sel  = S_STATUS;
      mt_data = 32'h0000_0000;
      cyc();
      rfe   = 1'b0;
      mt_en = 1'b0;
      rd(S_STATUS, 32'h0000_2000, "R10 rfe beats move-to");

      cyc();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule